// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits at the front of the execute stage of a five-stage in-order pipeline. For each of the two ALU operands it decides where the value comes from. The operand can be read from the register file. It can also be taken from the instruction one stage ahead, in the execute/memory register, or from the instruction two stages ahead, in the memory/writeback register. This covers the case where a result has been computed but not yet written back.

The decision compares each source register number with the destination register number of each older in-flight instruction. A match counts only when that older instruction writes a register and its destination is not register zero. The selector also contains the two operand multiplexers, so the ALU receives the chosen word directly. The block is purely combinational and holds no state. A change at any input shows at the select and operand outputs in the same cycle.

Top module: `fwd_unit`

## Requirements
- R1: When the execute/memory instruction writes a register, its destination is nonzero and it equals the source-A register number, `sel_a` is 2'b10 and `op_a` equals `exm_val`.
- R2: When the execute/memory instruction writes a register, its destination is nonzero and it equals the source-B register number, `sel_b` is 2'b10 and `op_b` equals `exm_val`.
- R3: When the memory/writeback instruction writes a nonzero destination equal to a source register number, and the execute/memory stage does not match that source, the select for that operand is 2'b01 and the operand equals `mwb_val`.
- R4: A destination register number of 0 never causes forwarding, even with its write enable set.
- R5: A stage whose write enable is 0 never causes forwarding, whatever its destination number.
- R6: When both stages match the same source register, the execute/memory stage is chosen (select 2'b10).
- R7: With no valid match, the select is 2'b00 and the operand equals the register-file value (`rf_a` for A, `rf_b` for B).
- R8: The two operands are resolved independently, so one operand may come from one stage while the other comes from the other stage in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs | input | 5 | Source-A register number of the execute-stage instruction |
| ex_rt | input | 5 | Source-B register number of the execute-stage instruction |
| exm_rd | input | 5 | Destination register number in the execute/memory register |
| exm_we | input | 1 | Register write enable in the execute/memory register |
| mwb_rd | input | 5 | Destination register number in the memory/writeback register |
| mwb_we | input | 1 | Register write enable in the memory/writeback register |
| rf_a | input | 32 | Register-file value read for source A |
| rf_b | input | 32 | Register-file value read for source B |
| exm_val | input | 32 | Result held in the execute/memory register |
| mwb_val | input | 32 | Result being written back from the memory/writeback register |
| sel_a | output | 2 | Operand-A source: 00 register file, 10 execute/memory, 01 memory/writeback |
| sel_b | output | 2 | Operand-B source, same encoding as sel_a |
| op_a | output | 32 | Selected operand A |
| op_b | output | 32 | Selected operand B |

## Verification
The block has no state, so a faulty match or priority decision shows up at once. It appears in the same evaluation as a select code that disagrees with the register numbers, and as an operand word taken from the wrong source. The stimulus chooses distinct data words for the three sources. Any wrong pick is then visible in the operand as well as in the select. The stimulus also sets up near-misses: register zero with write enable set, and matching numbers with write enable clear. These catch a comparator that ignores one of its qualifiers.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    parameter int REG_W  = 5;
    parameter int DATA_W = 32;
    parameter int N_OPS  = 2;
    parameter int N_SRC  = 2;

    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_RF  = 2'b00,
        SRC_MWB = 2'b01,
        SRC_EXM = 2'b10
    } src_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] rd;
        logic             we;
    } producer_t;

endpackage

// File: rtl/fwd_match.sv
module fwd_match
    import fwd_pkg::*;
#(
    parameter int RW = REG_W
) (
    input  logic [RW-1:0] src_reg,
    input  logic [RW-1:0] dst_reg,
    input  logic          dst_we,
    output logic          hit
);

    logic dst_nonzero;
    logic same_reg;

    always_comb begin
        dst_nonzero = |dst_reg;
        same_reg    = (src_reg == dst_reg);
        hit         = dst_we && dst_nonzero && same_reg;
    end

endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
    import fwd_pkg::*;
(
    input  logic     hit_near,
    input  logic     hit_far,
    output src_sel_e sel
);

    always_comb begin
        unique case ({hit_near, hit_far})
            2'b10, 2'b11: sel = SRC_EXM;
            2'b01:        sel = SRC_MWB;
            default:      sel = SRC_RF;
        endcase
    end

endmodule

// File: rtl/fwd_opmux.sv
module fwd_opmux
    import fwd_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  src_sel_e      sel,
    input  logic [DW-1:0] rf_val,
    input  logic [DW-1:0] near_val,
    input  logic [DW-1:0] far_val,
    output logic [DW-1:0] op
);

    always_comb begin
        unique case (sel)
            SRC_EXM: op = near_val;
            SRC_MWB: op = far_val;
            default: op = rf_val;
        endcase
    end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int DW = DATA_W
) (
    input  logic [RW-1:0] ex_rs,
    input  logic [RW-1:0] ex_rt,
    input  logic [RW-1:0] exm_rd,
    input  logic          exm_we,
    input  logic [RW-1:0] mwb_rd,
    input  logic          mwb_we,
    input  logic [DW-1:0] rf_a,
    input  logic [DW-1:0] rf_b,
    input  logic [DW-1:0] exm_val,
    input  logic [DW-1:0] mwb_val,
    output logic [1:0]    sel_a,
    output logic [1:0]    sel_b,
    output logic [DW-1:0] op_a,
    output logic [DW-1:0] op_b
);

    localparam int STG_NEAR = 0;
    localparam int STG_FAR  = 1;

    logic [RW-1:0] src_reg [N_OPS];
    logic [DW-1:0] rf_val  [N_OPS];
    logic [DW-1:0] op_val  [N_OPS];
    src_sel_e      sel     [N_OPS];
    producer_t     prod    [N_SRC];
    logic [N_SRC-1:0] hit  [N_OPS];

    always_comb begin
        src_reg[0]     = ex_rs;
        src_reg[1]     = ex_rt;
        rf_val[0]      = rf_a;
        rf_val[1]      = rf_b;
        prod[STG_NEAR] = '{rd: exm_rd, we: exm_we};
        prod[STG_FAR]  = '{rd: mwb_rd, we: mwb_we};
    end

    for (genvar o = 0; o < N_OPS; o++) begin : g_op
        for (genvar s = 0; s < N_SRC; s++) begin : g_stage
            fwd_match #(.RW(RW)) u_match (
                .src_reg (src_reg[o]),
                .dst_reg (prod[s].rd),
                .dst_we  (prod[s].we),
                .hit     (hit[o][s])
            );
        end

        fwd_pick u_pick (
            .hit_near (hit[o][STG_NEAR]),
            .hit_far  (hit[o][STG_FAR]),
            .sel      (sel[o])
        );

        fwd_opmux #(.DW(DW)) u_mux (
            .sel      (sel[o]),
            .rf_val   (rf_val[o]),
            .near_val (exm_val),
            .far_val  (mwb_val),
            .op       (op_val[o])
        );
    end

    always_comb begin
        sel_a = sel[0];
        sel_b = sel[1];
        op_a  = op_val[0];
        op_b  = op_val[1];
    end

endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
    parameter int RW = 5,
    parameter int DW = 32
) (
    input logic [RW-1:0] ex_rs,
    input logic [RW-1:0] ex_rt,
    input logic [RW-1:0] exm_rd,
    input logic          exm_we,
    input logic [RW-1:0] mwb_rd,
    input logic          mwb_we,
    input logic [DW-1:0] rf_a,
    input logic [DW-1:0] rf_b,
    input logic [DW-1:0] exm_val,
    input logic [DW-1:0] mwb_val,
    input logic [1:0]    sel_a,
    input logic [1:0]    sel_b,
    input logic [DW-1:0] op_a,
    input logic [DW-1:0] op_b
);

    always_comb begin
        a_r1_near_a_justified: assert (sel_a != 2'b10 ||
            (exm_we && exm_rd != '0 && exm_rd == ex_rs && op_a == exm_val));
        a_r2_near_b_justified: assert (sel_b != 2'b10 ||
            (exm_we && exm_rd != '0 && exm_rd == ex_rt && op_b == exm_val));
        a_r3_far_a_justified: assert (sel_a != 2'b01 ||
            (mwb_we && mwb_rd != '0 && mwb_rd == ex_rs && op_a == mwb_val));
        a_r3_far_b_justified: assert (sel_b != 2'b01 ||
            (mwb_we && mwb_rd != '0 && mwb_rd == ex_rt && op_b == mwb_val));
        a_r4_zero_reg_a: assert (ex_rs != '0 || sel_a == 2'b00);
        a_r4_zero_reg_b: assert (ex_rt != '0 || sel_b == 2'b00);
        a_r5_idle_stages: assert ((exm_we || mwb_we) || (sel_a == 2'b00 && sel_b == 2'b00));
        a_r6_near_wins: assert (!(exm_we && exm_rd != '0 && exm_rd == ex_rs) || sel_a == 2'b10);
        a_r7_rf_pass_a: assert (sel_a != 2'b00 || op_a == rf_a);
        a_r7_rf_pass_b: assert (sel_b != 2'b00 || op_b == rf_b);
        a_r8_legal_codes: assert (sel_a != 2'b11 && sel_b != 2'b11);
    end

endmodule

bind fwd_unit fwd_unit_chk #(.RW(RW), .DW(DW)) chk_i (
    .ex_rs   (ex_rs),
    .ex_rt   (ex_rt),
    .exm_rd  (exm_rd),
    .exm_we  (exm_we),
    .mwb_rd  (mwb_rd),
    .mwb_we  (mwb_we),
    .rf_a    (rf_a),
    .rf_b    (rf_b),
    .exm_val (exm_val),
    .mwb_val (mwb_val),
    .sel_a   (sel_a),
    .sel_b   (sel_b),
    .op_a    (op_a),
    .op_b    (op_b)
);

// File: tb/fwd_unit_tb_top.sv
module fwd_unit_tb_top;

    localparam int NVEC = 12;
    localparam int NRND = 300;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic done  = 1'b0;

    logic [4:0]  ex_rs   = '0;
    logic [4:0]  ex_rt   = '0;
    logic [4:0]  exm_rd  = '0;
    logic        exm_we  = 1'b0;
    logic [4:0]  mwb_rd  = '0;
    logic        mwb_we  = 1'b0;
    logic [31:0] rf_a    = 32'hA1A1_0001;
    logic [31:0] rf_b    = 32'hB2B2_0002;
    logic [31:0] exm_val = 32'hE3E3_0003;
    logic [31:0] mwb_val = 32'hD4D4_0004;
    logic [1:0]  sel_a;
    logic [1:0]  sel_b;
    logic [31:0] op_a;
    logic [31:0] op_b;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    fwd_unit dut_i (
        .ex_rs, .ex_rt, .exm_rd, .exm_we, .mwb_rd, .mwb_we,
        .rf_a, .rf_b, .exm_val, .mwb_val,
        .sel_a, .sel_b, .op_a, .op_b
    );

    // fields: rs, rt, exm_rd, exm_we, mwb_rd, mwb_we, exp_sel_a, exp_sel_b
    localparam logic [25:0] VEC [NVEC] = '{
        {5'd3,  5'd4,  5'd3,  1'b1, 5'd0, 1'b0, 2'b10, 2'b00},  // R1
        {5'd3,  5'd4,  5'd4,  1'b1, 5'd0, 1'b0, 2'b00, 2'b10},  // R2
        {5'd3,  5'd4,  5'd0,  1'b0, 5'd3, 1'b1, 2'b01, 2'b00},  // R3
        {5'd3,  5'd4,  5'd0,  1'b0, 5'd4, 1'b1, 2'b00, 2'b01},  // R3
        {5'd0,  5'd0,  5'd0,  1'b1, 5'd0, 1'b1, 2'b00, 2'b00},  // R4
        {5'd5,  5'd6,  5'd5,  1'b0, 5'd6, 1'b0, 2'b00, 2'b00},  // R5
        {5'd7,  5'd7,  5'd7,  1'b1, 5'd7, 1'b1, 2'b10, 2'b10},  // R6
        {5'd8,  5'd9,  5'd8,  1'b1, 5'd9, 1'b1, 2'b10, 2'b01},  // R8
        {5'd9,  5'd8,  5'd8,  1'b1, 5'd9, 1'b1, 2'b01, 2'b10},  // R8
        {5'd31, 5'd31, 5'd31, 1'b1, 5'd2, 1'b1, 2'b10, 2'b10},  // R1 R2
        {5'd1,  5'd2,  5'd3,  1'b1, 5'd4, 1'b1, 2'b00, 2'b00},  // R7
        {5'd7,  5'd7,  5'd7,  1'b0, 5'd7, 1'b1, 2'b01, 2'b01}   // R5 R6
    };

    function automatic logic [1:0] exp_sel(input logic [4:0] src);
        if (exm_we && exm_rd != 5'd0 && exm_rd == src) return 2'b10;
        if (mwb_we && mwb_rd != 5'd0 && mwb_rd == src) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [31:0] exp_op(input logic [1:0] s, input logic [31:0] rf);
        case (s)
            2'b10:   return exm_val;
            2'b01:   return mwb_val;
            default: return rf;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic [1:0] ea, input logic [1:0] eb);
        check({req, " sel_a"}, {30'd0, sel_a}, {30'd0, ea});
        check({req, " sel_b"}, {30'd0, sel_b}, {30'd0, eb});
        check({req, " op_a"}, op_a, exp_op(ea, rf_a));
        check({req, " op_b"}, op_b, exp_op(eb, rf_b));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R7 reset state", 2'b00, 2'b00);

        for (int i = 0; i < NVEC; i++) begin
            {ex_rs, ex_rt, exm_rd, exm_we, mwb_rd, mwb_we} = VEC[i][25:4];
            @(negedge clk);
            check_all($sformatf("vec%0d R1 R2 R3 R4 R5 R6 R7 R8", i), VEC[i][3:2], VEC[i][1:0]);
        end

        // R4: destination zero with write enable, sources zero, distinct data
        ex_rs = 5'd0; ex_rt = 5'd0; exm_rd = 5'd0; exm_we = 1'b1;
        mwb_rd = 5'd0; mwb_we = 1'b1;
        rf_a = 32'h1111_2222; rf_b = 32'h3333_4444;
        @(negedge clk);
        check("R4 op_a zero reg", op_a, 32'h1111_2222);
        check("R4 op_b zero reg", op_b, 32'h3333_4444);

        // R7: data change with no match passes straight through
        ex_rs = 5'd10; ex_rt = 5'd11; exm_rd = 5'd12; mwb_rd = 5'd13;
        rf_a = 32'hCAFE_0000; rf_b = 32'h0000_BEEF;
        @(negedge clk);
        check("R7 op_a passthru", op_a, 32'hCAFE_0000);
        check("R7 op_b passthru", op_b, 32'h0000_BEEF);

        // R1 R2 R3 R5 R6 R8: randomized sweep against requirement model
        for (int k = 0; k < NRND; k++) begin
            ex_rs   = 5'($urandom_range(0, 7));
            ex_rt   = 5'($urandom_range(0, 7));
            exm_rd  = 5'($urandom_range(0, 7));
            mwb_rd  = 5'($urandom_range(0, 7));
            exm_we  = 1'($urandom_range(0, 1));
            mwb_we  = 1'($urandom_range(0, 1));
            rf_a    = $urandom;
            rf_b    = $urandom;
            exm_val = $urandom;
            mwb_val = $urandom;
            @(negedge clk);
            check_all("rnd R1 R2 R3 R4 R5 R6 R7 R8", exp_sel(ex_rs), exp_sel(ex_rt));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule